// File: doc/BRIEF.md
# Dual-Line Vectored Interrupt Controller

This block collects level-sensitive interrupt requests from twenty-five sources and drives two processor exception lines: a normal interrupt line and a fast interrupt line. Each source has an enable bit and a steering bit. The steering bit picks which of the two lines the source raises. For each line, a fixed-priority resolver finds the most urgent pending source. A vector register returns that source's handler address, so a service routine can jump straight to the right handler.

External request pins are active-low and cross into the clock domain through a two-flop synchronizer. Timer, peripheral and processor-originated requests are active-high and already synchronous. An endpoint-mode input takes four of the external pins away from the request path. Those four positions then act as active-low interrupt outputs, driven from a software-written register. Software reaches every control and status field through a simple single-cycle register port.

Top module: `dual_line_intc`

## Requirements
- R1: Source indices are: 0 = dedicated high-priority pin, 1..16 = external pins 0..15, 17..18 = timers 0..1, 19..22 = peripherals 0..3, 23..24 = processor requests 0..1. The RAW status register (word 2) shows bit i = 1 while source i is active. For an external pin, that is its synchronized, inverted level, so a low pin shows in RAW two clock edges after it is driven. Internal sources show in the same cycle.
- R2: The ENABLE register (word 0) has bit i = 1 to enable source i. A disabled source never raises either line and never appears in pending status or in a vector.
- R3: In the STEER register (word 1), bit i = 0 sends source i to the normal line and bit i = 1 sends it to the fast line. An enabled source is pending on exactly one line. The IRQ pending register is word 3 and the FIQ pending register is word 4.
- R4: Requests are level sensitive. Pending status follows the request level, and nothing stays latched once the request is withdrawn.
- R5: `irq_o` and `fiq_o` are registered. Each asserts one clock edge after its line has any pending source. Each deasserts one clock edge after its last pending source is released, disabled or re-steered.
- R6: Within a line, the lowest source index wins. The high-priority pin (index 0) beats every other source.
- R7: The IRQ vector register (word 6) and the FIQ vector register (word 7) each read BASE + 32 × winning index, where BASE is the read/write register at word 5.
- R8: A vector register reads 0xFFFF_FFFF when its line has no pending source.
- R9: While `ep_mode` is 1, external pins 3..0 (indices 1..4) never produce a request or appear in RAW. In that mode, `ep_int_n[k]` is the inverse of bit k of the OUTBOUND register (word 8, bits 3..0) and `ep_int_oe` is 1. Otherwise `ep_int_n` is 4'hF and `ep_int_oe` is 0.
- R10: After reset, ENABLE, STEER, BASE and OUTBOUND are 0, and both lines are low.
- R11: Writes take effect at the clock edge where `bus_sel` and `bus_wr` are high. `bus_rdata` shows the addressed register in the same cycle. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_in_n | input | 1 | Dedicated high-priority request pin, active low |
| ext_in_n | input | 16 | Maskable external request pins, active low |
| tmr_req | input | 2 | Timer requests, active high |
| per_req | input | 4 | Peripheral requests, active high |
| cpu_req | input | 2 | Processor-originated requests, active high |
| ep_mode | input | 1 | Endpoint mode: pins 3..0 become outputs |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Register port write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| ep_int_n | output | 4 | Endpoint-mode interrupt outputs, active low |
| ep_int_oe | output | 1 | Output enable for `ep_int_n` |

## Verification
A steering write can land in the same cycle as an active request on the line it leaves. The bench provokes this by holding a timer request on the normal line and rewriting STEER to move it to the fast line. It then judges the handover edge by edge. The normal line stays high for the write edge, and on the next edge it falls in the same cycle as the fast line rises. No cycle may show both lines high or both low. A second overlap is the high-priority pin arriving while a lower source already owns the normal vector; the vector must switch without passing through the empty value.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int EXT_N     = 16;
    localparam int STRIDE_SH = 5;
    localparam logic [31:0] NO_VEC = 32'hFFFF_FFFF;

    localparam logic [3:0] A_ENABLE = 4'd0;
    localparam logic [3:0] A_STEER  = 4'd1;
    localparam logic [3:0] A_RAW    = 4'd2;
    localparam logic [3:0] A_PIRQ   = 4'd3;
    localparam logic [3:0] A_PFIQ   = 4'd4;
    localparam logic [3:0] A_BASE   = 4'd5;
    localparam logic [3:0] A_VIRQ   = 4'd6;
    localparam logic [3:0] A_VFIQ   = 4'd7;
    localparam logic [3:0] A_OUTB   = 4'd8;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_n,
    output logic [W-1:0] dout_n
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din_n;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: '1, s2: '1};
        else        st_q <= st_d;
    end

    assign dout_n = st_q.s2;
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int N  = 25,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> req[idx]); // R6
    AST_NONE_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((req & ((N'(1) << idx) - N'(1))) == '0)); // R6
    AST_EMPTY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (req == '0)); // R8
endmodule

// File: rtl/dual_line_intc.sv
module dual_line_intc #(
    parameter int NPER = 4,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hp_in_n,
    input  logic [15:0]     ext_in_n,
    input  logic [1:0]      tmr_req,
    input  logic [NPER-1:0] per_req,
    input  logic [1:0]      cpu_req,
    input  logic            ep_mode,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [3:0]      bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_o,
    output logic            fiq_o,
    output logic [3:0]      ep_int_n,
    output logic            ep_int_oe
);
    import intc_pkg::*;

    localparam int NSRC = 1 + EXT_N + 2 + NPER + 2;
    localparam int IDXW = $clog2(NSRC);
    localparam int NLINE = 2;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] steer;
        logic [DW-1:0]   base;
        logic [3:0]      outb;
        logic            irq;
        logic            fiq;
    } state_t;

    state_t q, d;

    logic [EXT_N:0]  sync_n;
    logic [EXT_N-1:0] ext_act;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] pend_irq, pend_fiq;
    logic [NSRC-1:0] line_req [NLINE];
    logic            win_v    [NLINE];
    logic [IDXW-1:0] win_idx  [NLINE];
    logic [DW-1:0]   vec      [NLINE];

    intc_sync #(.W(EXT_N + 1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_n  ({ext_in_n, hp_in_n}),
        .dout_n (sync_n)
    );

    always_comb begin
        ext_act = ~sync_n[EXT_N:1];
        if (ep_mode) ext_act[3:0] = 4'b0000;
    end

    assign raw      = {cpu_req, per_req, tmr_req, ext_act, ~sync_n[0]};
    assign pend_irq = raw & q.en & ~q.steer;
    assign pend_fiq = raw & q.en &  q.steer;
    assign line_req[0] = pend_irq;
    assign line_req[1] = pend_fiq;

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        intc_prio #(.N(NSRC), .IW(IDXW)) u_prio (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (line_req[g]),
            .valid (win_v[g]),
            .idx   (win_idx[g])
        );
        assign vec[g] = win_v[g] ? q.base + (DW'(win_idx[g]) << STRIDE_SH) : NO_VEC;
    end

    always_comb begin
        d = q;
        if (bus_sel && bus_wr) begin
            case (bus_addr)
                A_ENABLE: d.en    = bus_wdata[NSRC-1:0];
                A_STEER:  d.steer = bus_wdata[NSRC-1:0];
                A_BASE:   d.base  = bus_wdata;
                A_OUTB:   d.outb  = bus_wdata[3:0];
                default:  ;
            endcase
        end
        d.irq = |pend_irq;
        d.fiq = |pend_fiq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (bus_addr)
            A_ENABLE: bus_rdata = DW'(q.en);
            A_STEER:  bus_rdata = DW'(q.steer);
            A_RAW:    bus_rdata = DW'(raw);
            A_PIRQ:   bus_rdata = DW'(pend_irq);
            A_PFIQ:   bus_rdata = DW'(pend_fiq);
            A_BASE:   bus_rdata = q.base;
            A_VIRQ:   bus_rdata = vec[0];
            A_VFIQ:   bus_rdata = vec[1];
            A_OUTB:   bus_rdata = DW'(q.outb);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o     = q.irq;
    assign fiq_o     = q.fiq;
    assign ep_int_n  = ep_mode ? ~q.outb : 4'hF;
    assign ep_int_oe = ep_mode;

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        win_v[0] |=> irq_o); // R5
    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !win_v[0] |=> !irq_o); // R5
    AST_FIQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        win_v[1] |=> fiq_o); // R5
    AST_FIQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !win_v[1] |=> !fiq_o); // R5
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(raw & q.en))); // R2
    AST_EP_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ep_mode |-> !(win_v[0] && win_idx[0] >= IDXW'(1) && win_idx[0] <= IDXW'(4))); // R9
endmodule

// File: tb/test_dual_line_intc.sv
`timescale 1ns/1ps
module test_dual_line_intc;
    localparam logic [31:0] NOV = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hp_in_n = 1'b1;
    logic [15:0] ext_in_n = 16'hFFFF;
    logic [1:0]  tmr_req = '0;
    logic [3:0]  per_req = '0;
    logic [1:0]  cpu_req = '0;
    logic        ep_mode = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o, ep_int_oe;
    logic [3:0]  ep_int_n;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dual_line_intc i_dual_line_intc (
        .clk(clk), .rst_n(rst_n), .hp_in_n(hp_in_n), .ext_in_n(ext_in_n),
        .tmr_req(tmr_req), .per_req(per_req), .cpu_req(cpu_req),
        .ep_mode(ep_mode), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .ep_int_n(ep_int_n), .ep_int_oe(ep_int_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        chk("R10 irq", 32'(irq_o), 0);
        chk("R10 fiq", 32'(fiq_o), 0);
        rd(4'd0, v); chk("R10 enable", v, 0);
        rd(4'd5, v); chk("R10 base", v, 0);
        rd(4'd6, v); chk("R8 empty irq vec", v, NOV);
        rd(4'd7, v); chk("R8 empty fiq vec", v, NOV);
        chk("R9 pins idle", 32'(ep_int_n), 32'hF);
        chk("R9 oe idle", 32'(ep_int_oe), 0);
    endtask

    task automatic t_sync_mask();
        logic [31:0] v;
        ext_in_n[5] = 1'b0;
        @(negedge clk);
        rd(4'd2, v); chk("R1 raw after one edge", v, 0);
        @(negedge clk);
        rd(4'd2, v); chk("R1 raw after two edges", v, 32'h40);
        cycles(3);
        chk("R2 disabled no irq", 32'(irq_o), 0);
        rd(4'd3, v); chk("R2 disabled not pending", v, 0);
        wr(4'd0, 32'h40);
        @(negedge clk);
        chk("R2 enabled irq", 32'(irq_o), 1);
        ext_in_n[5] = 1'b1;
        cycles(4);
        chk("R4 pin released", 32'(irq_o), 0);
        wr(4'd0, 0);
    endtask

    task automatic t_timing();
        logic [31:0] v;
        wr(4'd0, 32'h0002_0000);
        tmr_req[0] = 1'b1;
        #1 chk("R5 not yet", 32'(irq_o), 0);
        @(negedge clk);
        chk("R5 rise one edge", 32'(irq_o), 1);
        rd(4'd3, v); chk("R3 irq pending", v, 32'h0002_0000);
        tmr_req[0] = 1'b0;
        #1 rd(4'd3, v); chk("R4 pending drops", v, 0);
        @(negedge clk);
        chk("R5 fall one edge", 32'(irq_o), 0);
        tmr_req[0] = 1'b1;
        @(negedge clk);
        chk("R4 no latch, reassert", 32'(irq_o), 1);
        wr(4'd1, 32'h0002_0000);
        chk("R3 collide: irq held on write edge", 32'(irq_o), 1);
        chk("R3 collide: fiq low on write edge", 32'(fiq_o), 0);
        @(negedge clk);
        chk("R3 handover irq", 32'(irq_o), 0);
        chk("R3 handover fiq", 32'(fiq_o), 1);
        rd(4'd4, v); chk("R3 fiq pending", v, 32'h0002_0000);
        tmr_req[0] = 1'b0;
        wr(4'd1, 0);
        wr(4'd0, 0);
        @(negedge clk);
        chk("R5 fiq fall", 32'(fiq_o), 0);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        wr(4'd5, 32'h0000_1000);
        rd(4'd5, v); chk("R11 base readback", v, 32'h1000);
        wr(4'd0, 32'hFFFF_FFFF);
        per_req[1] = 1'b1;
        cpu_req[0] = 1'b1;
        #1 rd(4'd6, v); chk("R7 vec idx20", v, 32'h1280);
        hp_in_n = 1'b0;
        @(negedge clk);
        rd(4'd6, v); chk("R6 hp not yet synced", v, 32'h1280);
        @(negedge clk);
        rd(4'd6, v); chk("R6 hp wins", v, 32'h1000);
        wr(4'd1, 32'h0080_0000);
        rd(4'd7, v); chk("R7 fiq vec idx23", v, 32'h12E0);
        hp_in_n = 1'b1;
        per_req[1] = 1'b0;
        cycles(3);
        rd(4'd6, v); chk("R8 irq line empty", v, NOV);
        cpu_req[0] = 1'b0;
        #1 rd(4'd7, v); chk("R8 fiq line empty", v, NOV);
        wr(4'd1, 0);
        wr(4'd0, 0);
    endtask

    task automatic t_endpoint();
        logic [31:0] v;
        wr(4'd0, 32'h1E);
        ep_mode = 1'b1;
        ext_in_n[2] = 1'b0;
        cycles(4);
        chk("R9 pin2 no irq", 32'(irq_o), 0);
        rd(4'd2, v); chk("R9 pin2 not raw", v, 0);
        wr(4'd8, 32'h5);
        chk("R9 outputs", 32'(ep_int_n), 32'hA);
        chk("R9 oe", 32'(ep_int_oe), 1);
        ep_mode = 1'b0;
        @(negedge clk);
        chk("R9 pin2 back as request", 32'(irq_o), 1);
        chk("R9 outputs released", 32'(ep_int_n), 32'hF);
        ext_in_n[2] = 1'b1;
        rd(4'd15, v); chk("R11 unmapped reads zero", v, 0);
        wr(4'd0, 0);
        cycles(3);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        t_reset();
        t_sync_mask();
        t_timing();
        t_prio();
        t_endpoint();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule